// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional byte buses, side A and side B. Each bus appears at the block's edge as a separate input, output and output-enable triple, so the tri-state driver sits outside the block. Each direction has its own capture register and its own capture clock. The A-to-B register samples side A, and the B-to-A register samples side B. The two clocks are unrelated, so a direction captures only when its own clock has a rising edge.

An active-low enable and a direction input decide which side, if either, is driven. A per-direction source select then picks what goes out on the driven side: either the live value from the opposite side, passed through combinationally, or the value held in that direction's register.

Capture is never blocked by the output controls. Either register, or both, can load while the block is isolated or while either side is being driven. These pins are plain level controls. The block has no valid/ready handshake and exerts no back-pressure, because data moves at bus speed and a held value stays until its own clock edge overwrites it.

Top module: `xcvr_reg_bidir`

## Requirements
- R1: When `oe_n` is 1, both `a_oe` and `b_oe` are 0 (isolation), whatever the values of `dir` and the selects.
- R2: When `oe_n` is 0, `dir` = 1 drives side B (`b_oe` = 1, `a_oe` = 0) and `dir` = 0 drives side A (`a_oe` = 1, `b_oe` = 0).
- R3: `a_oe` and `b_oe` are never 1 at the same time.
- R4: With side B driven and `sel_ab` = 0, `b_out` equals `a_in` in the same cycle, with no clock delay.
- R5: With side B driven and `sel_ab` = 1, `b_out` equals the A-to-B register contents.
- R6: With side A driven, `a_out` equals `b_in` when `sel_ba` = 0 and equals the B-to-A register contents when `sel_ba` = 1.
- R7: The A-to-B register loads `a_in` on each rising edge of `clk_ab`, and the B-to-A register loads `b_in` on each rising edge of `clk_ba`. Each register is unaffected by the other register's clock.
- R8: Both registers capture on their own clock edges while `oe_n` = 1, and for any value of `dir`.
- R9: Without an edge on its own clock, a register keeps its value across any changes of `oe_n`, `dir`, the selects and the bus inputs.
- R10: `rst` = 1 at a rising edge of a register's clock clears that register to zero (synchronous reset). The other register is left unchanged.
- R11: A data output whose enable is 0 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous reset, active high, applied per register on its own clock |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive side B; 0: drive side A |
| sel_ab | input | 1 | Source for side B: 0 live `a_in`, 1 stored |
| sel_ba | input | 1 | Source for side A: 0 live `b_in`, 1 stored |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench fires the two capture clocks one at a time and together, while it toggles isolation and direction. A design that gated capture with the enable would lose the isolated loads. A design that shared one clock between the registers would corrupt the register that was not clocked. The bench also changes the bus inputs between edges while the stored source is selected. A stored path that leaked live data would then show the new input instead of the held byte, and a transparent path given a register stage would lag by one edge. Finally, the bench applies a reset with only one clock running and checks that only that register clears.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_sel_e;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_B    = 2'd1,
    DRV_A    = 2'd2
  } drive_e;

  localparam int unsigned NUM_DIRS = 2;
  localparam int unsigned IDX_AB   = 0;
  localparam int unsigned IDX_BA   = 1;
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R7
  capture_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q == $past(d)));

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
  import xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_e mode,
  output logic   a_en,
  output logic   b_en
);
  always_comb begin
    if (oe_n)     mode = DRV_NONE;
    else if (dir) mode = DRV_B;
    else          mode = DRV_A;
  end

  assign a_en = (mode == DRV_A);
  assign b_en = (mode == DRV_B);
endmodule

// File: rtl/xcvr_source_mux.sv
module xcvr_source_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_sel_e     sel,
  input  logic         en,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] dout
);
  logic [W-1:0] picked;

  always_comb begin
    unique case (sel)
      SRC_LIVE: picked = live;
      SRC_HELD: picked = held;
      default:  picked = live;
    endcase
  end

  assign dout = en ? picked : '0;
endmodule

// File: rtl/xcvr_reg_bidir.sv
module xcvr_reg_bidir
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [NUM_DIRS-1:0]        cap_clk;
  logic [NUM_DIRS-1:0][W-1:0] cap_d;
  logic [NUM_DIRS-1:0][W-1:0] cap_q;
  logic [NUM_DIRS-1:0]        drv_en;
  logic [NUM_DIRS-1:0]        sel_raw;
  logic [NUM_DIRS-1:0][W-1:0] drv_out;
  drive_e                     mode;
  logic                       en_a;
  logic                       en_b;

  // Index IDX_AB: A is captured and drives B. Index IDX_BA: the reverse.
  assign cap_clk[IDX_AB] = clk_ab;
  assign cap_clk[IDX_BA] = clk_ba;
  assign cap_d[IDX_AB]   = a_in;
  assign cap_d[IDX_BA]   = b_in;
  assign sel_raw[IDX_AB] = sel_ab;
  assign sel_raw[IDX_BA] = sel_ba;
  assign drv_en[IDX_AB]  = en_b;
  assign drv_en[IDX_BA]  = en_a;

  xcvr_drive_ctrl u_ctrl (
    .oe_n (oe_n),
    .dir  (dir),
    .mode (mode),
    .a_en (en_a),
    .b_en (en_b)
  );

  for (genvar i = 0; i < NUM_DIRS; i++) begin : g_dir
    src_sel_e sel_e;
    assign sel_e = src_sel_e'(sel_raw[i]);

    xcvr_capture #(.W(W)) u_cap (
      .clk (cap_clk[i]),
      .rst (rst),
      .d   (cap_d[i]),
      .q   (cap_q[i])
    );

    xcvr_source_mux #(.W(W)) u_mux (
      .sel  (sel_e),
      .en   (drv_en[i]),
      .live (cap_d[i]),
      .held (cap_q[i]),
      .dout (drv_out[i])
    );
  end

  assign b_out = drv_out[IDX_AB];
  assign a_out = drv_out[IDX_BA];
  assign a_oe  = en_a;
  assign b_oe  = en_b;

  always_comb begin
    // R3
    one_driver_chk: assert (!(a_oe && b_oe));
    // R1
    isolation_chk: assert (!oe_n || (!a_oe && !b_oe));
    // R11
    idle_a_zero_chk: assert (a_oe || (a_out == '0));
    // R11
    idle_b_zero_chk: assert (b_oe || (b_out == '0));
  end
endmodule

// File: tb/xcvr_reg_bidir_tb.sv
module xcvr_reg_bidir_tb;
  localparam int W = 8;

  logic sys_clk = 1'b0;
  logic gate_ab = 1'b0;
  logic gate_ba = 1'b0;
  logic rst = 1'b0;
  logic oe_n = 1'b1;
  logic dir = 1'b0;
  logic sel_ab = 1'b0;
  logic sel_ba = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic clk_ab, clk_ba;

  int checks = 0;
  int errors = 0;
  int m_ab = 0;
  int m_ba = 0;
  bit done = 0;

  always #10 sys_clk = ~sys_clk;
  assign clk_ab = sys_clk & gate_ab;
  assign clk_ba = sys_clk & gate_ba;

  xcvr_reg_bidir #(.W(W)) u_dut (
    .clk_ab (clk_ab), .clk_ba (clk_ba), .rst (rst),
    .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
    .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive on the falling edge, pulse the chosen clocks, compare 5 ns after the rise.
  task automatic step(string tag, bit r, bit on, bit d, bit sab, bit sba,
                      int av, int bv, bit pab, bit pba);
    int eb_oe, ea_oe, eb, ea;
    @(negedge sys_clk);
    rst = r; oe_n = on; dir = d; sel_ab = sab; sel_ba = sba;
    a_in = av[W-1:0]; b_in = bv[W-1:0]; gate_ab = pab; gate_ba = pba;
    @(posedge sys_clk);
    if (pab) m_ab = r ? 0 : av;
    if (pba) m_ba = r ? 0 : bv;
    #5;
    eb_oe = (!on && d) ? 1 : 0;
    ea_oe = (!on && !d) ? 1 : 0;
    eb = eb_oe ? (sab ? m_ab : av) : 0;
    ea = ea_oe ? (sba ? m_ba : bv) : 0;
    chk("R2", "b_oe", int'(b_oe), eb_oe);
    chk("R2", "a_oe", int'(a_oe), ea_oe);
    chk("R3", "both enables", int'(a_oe && b_oe), 0);
    chk(tag, "b_out", int'(b_out), eb);
    chk(tag, "a_out", int'(a_out), ea);
  endtask

  initial begin
    int lfsr;
    // R10 reset clears both registers
    step("R10", 1, 1, 0, 0, 0, 8'h5A, 8'hA5, 1, 1);
    step("R10", 0, 0, 1, 1, 0, 8'h11, 8'h22, 0, 0);
    step("R10", 0, 0, 0, 0, 1, 8'h33, 8'h44, 0, 0);
    // R1 isolation with every select setting; R11 idle outputs are zero
    step("R1", 0, 1, 1, 1, 1, 8'hFF, 8'hFF, 0, 0);
    step("R11", 0, 1, 0, 0, 0, 8'h81, 8'h18, 0, 0);
    // R4 transparent A to B, several patterns
    step("R4", 0, 0, 1, 0, 0, 8'h55, 8'h00, 0, 0);
    step("R4", 0, 0, 1, 0, 0, 8'hAA, 8'h00, 0, 0);
    step("R4", 0, 0, 1, 0, 0, 8'h3C, 8'h00, 0, 0);
    // R7 capture A, then R5 stored value survives changes on a_in
    step("R7", 0, 0, 1, 0, 0, 8'hA5, 8'h00, 1, 0);
    step("R5", 0, 0, 1, 1, 0, 8'h00, 8'h00, 0, 0);
    step("R5", 0, 0, 1, 1, 0, 8'h7E, 8'h00, 0, 0);
    // R6 B to A: stored and live
    step("R7", 0, 0, 0, 0, 0, 8'h00, 8'hC3, 0, 1);
    step("R6", 0, 0, 0, 0, 1, 8'h00, 8'h99, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 8'h00, 8'h77, 0, 0);
    // R8 capture while isolated, both clocks together, then read out
    step("R8", 0, 1, 0, 1, 1, 8'h0F, 8'hF0, 1, 1);
    step("R8", 0, 0, 1, 1, 1, 8'h00, 8'h00, 0, 0);
    step("R8", 0, 0, 0, 1, 1, 8'h00, 8'h00, 0, 0);
    // R8 capture while the other side is driven
    step("R8", 0, 0, 0, 0, 1, 8'h6B, 8'h00, 1, 0);
    step("R8", 0, 0, 1, 1, 0, 8'h00, 8'h00, 0, 0);
    // R9 hold across control and bus changes without edges
    for (int i = 0; i < 8; i++)
      step("R9", 0, i[0], i[1], 1, 1, i * 37, i * 53, 0, 0);
    // R7 independence: only clk_ab fires, B-to-A register untouched
    step("R7", 0, 0, 1, 1, 1, 8'hE1, 8'h1E, 1, 0);
    step("R7", 0, 0, 0, 1, 1, 8'h00, 8'h00, 0, 0);
    // R10 reset seen only through clk_ab clears only that register
    step("R10", 1, 1, 0, 1, 1, 8'h00, 8'h00, 1, 0);
    step("R10", 0, 0, 1, 1, 1, 8'h00, 8'h00, 0, 0);
    step("R10", 0, 0, 0, 1, 1, 8'h00, 8'h00, 0, 0);
    // R3 mixed stimulus
    lfsr = 32'h1D2C3B4A;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R3", 0, lfsr[0], lfsr[1], lfsr[2], lfsr[3],
           (lfsr >> 8) & 255, (lfsr >> 16) & 255, lfsr[4], lfsr[5]);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge sys_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule